// File: doc/BRIEF.md
# Serial EEPROM Bus Slave Controller

This block is the two-wire bus front end of a byte-addressed nonvolatile memory. It oversamples the clock and data lines with a fast system clock and recognises start and stop conditions. It checks the first byte of each command against a fixed device type and three chip-enable pins. For writes it collects a 16-bit memory address followed by data bytes. For reads it returns bytes from its memory port. It drives the data line only by pulling it low, through an output-enable signal.

Each data byte that is accepted during a write is passed on as a one-cycle write pulse on a simple memory port. A separate write-cycle engine latches these bytes. When the master closes the transfer correctly, the block issues a single commit strobe to that engine. While the engine reports busy, the block acknowledges nothing, so a master can poll until the engine is done. A write-protect pin lets the select and address bytes through but refuses every data byte.

Top module: `eeprom_bus_slave`

## Requirements
- R1: After reset `sda_oe`, `mem_we` and `commit` are low. A falling data line while the clock is high is a start. A rising data line while the clock is high is a stop. A command is decoded only after a start.
- R2: The first byte after a start is taken MSB first. Bits 7:4 must be 1010 and bits 3:1 must equal `chip_en[2:0]`, where bit 3 is compared with `chip_en[2]`. Bit 0 selects read (1) or write (0). On a match the block pulls the data line low for the ninth clock. On a mismatch it never drives the line, and it ignores later bytes until the next start.
- R3: While `busy_i` is high, a matching select byte is not acknowledged.
- R4: In a write, the two bytes after the select byte are acknowledged. They form the byte address, high byte first. Each acknowledged data byte gives a `mem_wdata`/`mem_addr` write. After each such byte the address increments in its low `PAGE_BITS` bits only, wrapping inside the page.
- R5: While `wr_protect` is high, data bytes get no acknowledge and produce no `mem_we`. Select and address bytes are still acknowledged.
- R6: `sda_oe` changes only while the sampled clock line is low.
- R7: `commit` pulses once for a stop that arrives directly after an acknowledged data byte. A stop after the address bytes, in the middle of a byte, or after a refused byte gives no commit.
- R8: In a read, the block shifts out the byte at the current address MSB first. The full 16-bit address increments after every byte. Reading continues while the master acknowledges, and the block releases the line after a master no-acknowledge.
- R9: A repeated start abandons the current byte and restarts select decoding. The address is kept, so a random read works. A write that was not closed by a qualifying stop is never committed.
- R10: `mem_we` is never high for two consecutive cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, much faster than the bus clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| scl_i | input | 1 | Bus clock line |
| sda_i | input | 1 | Bus data line as seen on the wire |
| sda_oe | output | 1 | When high, the data line is pulled low |
| chip_en | input | 3 | Device address pins compared with select bits 3:1 |
| wr_protect | input | 1 | High refuses all data bytes of writes |
| busy_i | input | 1 | Write-cycle engine busy flag |
| mem_addr | output | 16 | Current byte address |
| mem_wdata | output | 8 | Byte to be latched on `mem_we` |
| mem_rdata | input | 8 | Byte stored at `mem_addr` |
| mem_we | output | 1 | One-cycle strobe for an accepted data byte |
| commit | output | 1 | One-cycle request to start the internal write cycle |

## Verification
Two decisions can land on the same sampled edge: a stop being judged as a commit, and the first bit of the next data byte being shifted in. A stop needs a rising clock first, so that bit is always taken before the stop is seen. The bench provokes this by closing a write right after a data acknowledge, then again after four more bits and after a repeated start. Only the first case may raise the commit count. It also raises the busy flag during a select byte and requires the acknowledge slot to stay released.

// File: rtl/eeprom_slave_pkg.sv
package eeprom_slave_pkg;

    localparam int unsigned ADDR_W   = 16;
    localparam int unsigned BYTE_W   = 8;
    localparam logic [3:0]  DEV_TYPE = 4'b1010;

    typedef enum logic [2:0] {
        PH_IDLE,
        PH_SEL,
        PH_AHI,
        PH_ALO,
        PH_WR,
        PH_RD
    } phase_e;

    typedef struct packed {
        phase_e              phase;
        logic [3:0]          bitcnt;
        logic [BYTE_W-1:0]   shreg;
        logic [ADDR_W-1:0]   addr;
        logic                oe;
        logic                armed;
        logic                we;
        logic                commit;
    } ctl_s;

endpackage

// File: rtl/i2c_line_sampler.sv
module i2c_line_sampler #(
    parameter int unsigned STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic scl_i,
    input  logic sda_i,
    output logic scl_lvl,
    output logic sda_lvl,
    output logic scl_rise,
    output logic scl_fall,
    output logic ev_start,
    output logic ev_stop
);

    logic [STAGES-1:0] scl_sr;
    logic [STAGES-1:0] sda_sr;
    logic              scl_prev;
    logic              sda_prev;

    for (genvar k = 0; k < STAGES; k++) begin : g_sync
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                scl_sr[k] <= 1'b1;
                sda_sr[k] <= 1'b1;
            end else if (k == 0) begin
                scl_sr[k] <= scl_i;
                sda_sr[k] <= sda_i;
            end else begin
                scl_sr[k] <= scl_sr[(k == 0) ? 0 : k-1];
                sda_sr[k] <= sda_sr[(k == 0) ? 0 : k-1];
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            scl_prev <= 1'b1;
            sda_prev <= 1'b1;
        end else begin
            scl_prev <= scl_lvl;
            sda_prev <= sda_lvl;
        end
    end

    assign scl_lvl  = scl_sr[STAGES-1];
    assign sda_lvl  = sda_sr[STAGES-1];
    assign scl_rise = scl_lvl & ~scl_prev;
    assign scl_fall = ~scl_lvl & scl_prev;
    assign ev_start = scl_lvl & scl_prev & sda_prev & ~sda_lvl;
    assign ev_stop  = scl_lvl & scl_prev & ~sda_prev & sda_lvl;

endmodule

// File: rtl/addr_stepper.sv
module addr_stepper #(
    parameter int unsigned ADDR_W    = 16,
    parameter int unsigned PAGE_BITS = 6
) (
    input  logic [ADDR_W-1:0] addr_i,
    input  logic              page_wrap_i,
    output logic [ADDR_W-1:0] addr_o
);

    logic [ADDR_W-1:0] full_inc;
    assign full_inc = addr_i + 1'b1;

    if (PAGE_BITS >= ADDR_W) begin : g_nopage
        assign addr_o = full_inc;
    end else begin : g_page
        logic [PAGE_BITS-1:0] low_inc;
        assign low_inc = addr_i[PAGE_BITS-1:0] + 1'b1;
        assign addr_o  = page_wrap_i ? {addr_i[ADDR_W-1:PAGE_BITS], low_inc}
                                     : full_inc;
    end

endmodule

// File: rtl/eeprom_bus_slave.sv
module eeprom_bus_slave
    import eeprom_slave_pkg::*;
#(
    parameter int unsigned PAGE_BITS   = 6,
    parameter int unsigned SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              scl_i,
    input  logic              sda_i,
    output logic              sda_oe,
    input  logic [2:0]        chip_en,
    input  logic              wr_protect,
    input  logic              busy_i,
    output logic [ADDR_W-1:0] mem_addr,
    output logic [BYTE_W-1:0] mem_wdata,
    input  logic [BYTE_W-1:0] mem_rdata,
    output logic              mem_we,
    output logic              commit
);

    localparam logic [3:0] CNT_FULL  = 4'(BYTE_W);
    localparam logic [3:0] CNT_SLOT  = CNT_FULL + 4'd1;
    localparam logic [3:0] CNT_MACK  = CNT_FULL + 4'd2;

    logic scl_lvl, sda_lvl, scl_rise, scl_fall, ev_start, ev_stop;
    logic sel_hit;
    logic [ADDR_W-1:0] addr_page, addr_full;
    ctl_s q, d;
    phase_e     cur_phase;
    logic [3:0] cur_bitcnt;

    i2c_line_sampler #(.STAGES(SYNC_STAGES)) u_lines (
        .clk(clk), .rst_n(rst_n), .scl_i(scl_i), .sda_i(sda_i),
        .scl_lvl(scl_lvl), .sda_lvl(sda_lvl),
        .scl_rise(scl_rise), .scl_fall(scl_fall),
        .ev_start(ev_start), .ev_stop(ev_stop)
    );

    addr_stepper #(.ADDR_W(ADDR_W), .PAGE_BITS(PAGE_BITS)) u_step_page (
        .addr_i(q.addr), .page_wrap_i(1'b1), .addr_o(addr_page)
    );

    addr_stepper #(.ADDR_W(ADDR_W), .PAGE_BITS(PAGE_BITS)) u_step_full (
        .addr_i(q.addr), .page_wrap_i(1'b0), .addr_o(addr_full)
    );

    assign sel_hit = (q.shreg[7:4] == DEV_TYPE) && (q.shreg[3:1] == chip_en) && !busy_i;

    always_comb begin
        logic ack;
        d        = q;
        d.we     = 1'b0;
        d.commit = 1'b0;
        ack      = 1'b0;
        if (ev_stop) begin
            // qualifying stop: first bit after an accepted data byte
            d.commit = q.armed && (q.phase == PH_WR) && (q.bitcnt <= 4'd1);
            d.phase  = PH_IDLE;
            d.bitcnt = '0;
            d.oe     = 1'b0;
            d.armed  = 1'b0;
        end else if (ev_start) begin
            d.phase  = PH_SEL;
            d.bitcnt = '0;
            d.oe     = 1'b0;
            d.armed  = 1'b0;
        end else if (q.phase == PH_RD) begin
            if (scl_rise) begin
                if (q.bitcnt == CNT_SLOT) begin
                    if (sda_lvl) begin
                        d.phase  = PH_IDLE;
                        d.bitcnt = '0;
                    end else begin
                        d.bitcnt = CNT_MACK;
                    end
                end else if (q.bitcnt < CNT_FULL) begin
                    d.bitcnt = q.bitcnt + 4'd1;
                end
            end else if (scl_fall) begin
                if (q.bitcnt == CNT_FULL) begin
                    d.oe     = 1'b0;
                    d.addr   = addr_full;
                    d.bitcnt = CNT_SLOT;
                end else if (q.bitcnt == CNT_MACK) begin
                    d.shreg  = mem_rdata;
                    d.oe     = ~mem_rdata[BYTE_W-1];
                    d.bitcnt = '0;
                end else if (q.bitcnt != 4'd0) begin
                    d.shreg  = {q.shreg[BYTE_W-2:0], 1'b0};
                    d.oe     = ~q.shreg[BYTE_W-2];
                end
            end
        end else if (q.phase != PH_IDLE) begin
            if (scl_rise && q.bitcnt < CNT_FULL) begin
                d.shreg  = {q.shreg[BYTE_W-2:0], sda_lvl};
                d.bitcnt = q.bitcnt + 4'd1;
            end else if (scl_fall && q.bitcnt == CNT_FULL) begin
                unique case (q.phase)
                    PH_SEL: ack = sel_hit;
                    PH_AHI: begin
                        ack = 1'b1;
                        d.addr[ADDR_W-1:BYTE_W] = q.shreg;
                    end
                    PH_ALO: begin
                        ack = 1'b1;
                        d.addr[BYTE_W-1:0] = q.shreg;
                    end
                    default: begin
                        ack     = !wr_protect;
                        d.we    = ack;
                        d.armed = ack;
                    end
                endcase
                d.oe     = ack;
                d.bitcnt = CNT_SLOT;
                if (q.phase == PH_SEL && !ack) begin
                    d.phase  = PH_IDLE;
                    d.bitcnt = '0;
                end
            end else if (scl_fall && q.bitcnt == CNT_SLOT) begin
                d.oe     = 1'b0;
                d.bitcnt = '0;
                unique case (q.phase)
                    PH_SEL: begin
                        if (q.shreg[0]) begin
                            d.phase = PH_RD;
                            d.shreg = mem_rdata;
                            d.oe    = ~mem_rdata[BYTE_W-1];
                        end else begin
                            d.phase = PH_AHI;
                        end
                    end
                    PH_AHI:  d.phase = PH_ALO;
                    PH_ALO:  d.phase = PH_WR;
                    default: if (q.armed) d.addr = addr_page;
                endcase
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q <= '{phase: PH_IDLE, default: '0};
        end else begin
            q <= d;
        end
    end

    assign sda_oe     = q.oe;
    assign mem_addr   = q.addr;
    assign mem_wdata  = q.shreg;
    assign mem_we     = q.we;
    assign commit     = q.commit;
    assign cur_phase  = q.phase;
    assign cur_bitcnt = q.bitcnt;

endmodule

// File: rtl/eeprom_slave_chk.sv
module eeprom_slave_chk
    import eeprom_slave_pkg::*;
(
    input logic       clk,
    input logic       rst_n,
    input logic       scl_lvl,
    input logic       scl_fall,
    input logic       ev_stop,
    input logic       busy_i,
    input logic       wr_protect,
    input logic       sda_oe,
    input logic       mem_we,
    input logic       commit,
    input phase_e     cur_phase,
    input logic [3:0] cur_bitcnt
);

    // R3
    busy_select_nack_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cur_phase == PH_SEL && cur_bitcnt == 4'd8 && scl_fall && busy_i) |=> !sda_oe);

    // R5
    protect_data_refused_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cur_phase == PH_WR && cur_bitcnt == 4'd8 && scl_fall && wr_protect) |=> (!sda_oe && !mem_we));

    // R6
    drive_on_low_clock_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(sda_oe) |-> !$past(scl_lvl));

    // R7
    commit_needs_stop_chk: assert property (@(posedge clk) disable iff (!rst_n)
        commit |-> $past(ev_stop));

    // R10
    we_single_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        mem_we |=> !mem_we);

endmodule

bind eeprom_bus_slave eeprom_slave_chk u_chk (
    .clk(clk), .rst_n(rst_n), .scl_lvl(scl_lvl), .scl_fall(scl_fall),
    .ev_stop(ev_stop), .busy_i(busy_i), .wr_protect(wr_protect),
    .sda_oe(sda_oe), .mem_we(mem_we), .commit(commit),
    .cur_phase(cur_phase), .cur_bitcnt(cur_bitcnt)
);

// File: tb/tb_eeprom_bus_slave.sv
module tb_eeprom_bus_slave;

    localparam int CLK_PERIOD = 10;
    localparam int QP         = 8;
    localparam logic [2:0] CHIP = 3'b101;

    typedef struct packed {
        logic [7:0]  sel;
        logic [15:0] addr;
        logic [7:0]  data;
        logic        wp;
    } wvec_t;

    localparam wvec_t WTAB [5] = '{
        '{sel: 8'hAA, addr: 16'h0010, data: 8'h5A, wp: 1'b0},
        '{sel: 8'hAA, addr: 16'h0123, data: 8'hC3, wp: 1'b0},
        '{sel: 8'hAA, addr: 16'h0011, data: 8'h77, wp: 1'b1},
        '{sel: 8'hA8, addr: 16'h0040, data: 8'h01, wp: 1'b0},
        '{sel: 8'hBA, addr: 16'h0041, data: 8'h02, wp: 1'b0}
    };

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic scl = 1'b1;
    logic sda_m = 1'b1;
    logic wr_protect = 1'b0;
    logic busy = 1'b0;
    logic sda_oe, mem_we, commit;
    logic [15:0] mem_addr;
    logic [7:0]  mem_wdata, mem_rdata;
    logic sda_bus;

    logic [7:0]  mem [256];
    logic [15:0] wlog_addr [16];
    logic [7:0]  wlog_data [16];
    int wcount = 0;
    int ccount = 0;
    int oe_viol = 0;
    int we_run = 0;
    logic oe_prev = 1'b0;
    int checks = 0;
    int fails = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    assign sda_bus   = sda_m & ~sda_oe;
    assign mem_rdata = mem[mem_addr[7:0]];

    eeprom_bus_slave dut (
        .clk(clk), .rst_n(rst_n), .scl_i(scl), .sda_i(sda_bus), .sda_oe(sda_oe),
        .chip_en(CHIP), .wr_protect(wr_protect), .busy_i(busy),
        .mem_addr(mem_addr), .mem_wdata(mem_wdata), .mem_rdata(mem_rdata),
        .mem_we(mem_we), .commit(commit)
    );

    // model of the write-cycle engine and output monitors
    always @(negedge clk) begin
        if (rst_n) begin
            if (mem_we) begin
                mem[mem_addr[7:0]] = mem_wdata;
                if (wcount < 16) begin
                    wlog_addr[wcount] = mem_addr;
                    wlog_data[wcount] = mem_wdata;
                end
                wcount++;
                we_run++;
            end else begin
                we_run = 0;
            end
            if (we_run > 1) oe_viol += 1000;
            if (commit) ccount++;
            if (sda_oe != oe_prev && scl) oe_viol++;
            oe_prev = sda_oe;
        end
    end

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual %0h expected %0h", req, act, exp);
        end
    endtask

    task automatic wq(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic bus_start();
        sda_m = 1'b1; wq(QP);
        scl = 1'b1;   wq(QP);
        sda_m = 1'b0; wq(QP);
        scl = 1'b0;   wq(QP);
    endtask

    task automatic bus_stop();
        sda_m = 1'b0; wq(QP);
        scl = 1'b1;   wq(QP);
        sda_m = 1'b1; wq(QP);
    endtask

    task automatic send_bit(input logic b);
        sda_m = b; wq(QP);
        scl = 1'b1; wq(2*QP);
        scl = 1'b0; wq(QP);
    endtask

    task automatic send_byte(input logic [7:0] b, output logic acked);
        for (int i = 7; i >= 0; i--) send_bit(b[i]);
        sda_m = 1'b1; wq(QP);
        scl = 1'b1;   wq(QP);
        acked = ~sda_bus;
        wq(QP);
        scl = 1'b0;   wq(QP);
    endtask

    task automatic recv_byte(input logic mack, output logic [7:0] b);
        sda_m = 1'b1;
        for (int i = 7; i >= 0; i--) begin
            wq(QP);
            scl = 1'b1; wq(QP);
            b[i] = sda_bus;
            wq(QP);
            scl = 1'b0;
        end
        wq(QP);
        sda_m = ~mack;
        scl = 1'b1; wq(2*QP);
        scl = 1'b0; wq(QP);
        sda_m = 1'b1;
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        checks++;
        fails++;
        $display("FAIL watchdog actual running expected finished");
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

    initial begin
        logic a;
        logic [7:0] rb;
        int wc0, cc0;
        for (int i = 0; i < 256; i++) mem[i] = 8'(i) ^ 8'h96;
        wq(5);
        // R1 reset state
        chk("R1 sda_oe at reset", 32'(sda_oe), 0);
        chk("R1 mem_we at reset", 32'(mem_we), 0);
        chk("R1 commit at reset", 32'(commit), 0);
        rst_n = 1'b1;
        wq(5);

        // table-driven single-byte writes
        for (int t = 0; t < 5; t++) begin
            logic exp_sel, exp_dat;
            exp_sel = (WTAB[t].sel[7:4] == 4'hA) && (WTAB[t].sel[3:1] == CHIP);
            exp_dat = exp_sel && !WTAB[t].wp;
            wc0 = wcount; cc0 = ccount;
            wr_protect = WTAB[t].wp;
            bus_start();
            send_byte(WTAB[t].sel, a);
            chk("R2 select acknowledge", 32'(a), 32'(exp_sel));
            send_byte(WTAB[t].addr[15:8], a);
            chk("R4 high address acknowledge", 32'(a), 32'(exp_sel));
            send_byte(WTAB[t].addr[7:0], a);
            chk("R4 low address acknowledge", 32'(a), 32'(exp_sel));
            send_byte(WTAB[t].data, a);
            chk("R5 data acknowledge", 32'(a), 32'(exp_dat));
            bus_stop();
            wq(4);
            chk("R5 write strobes", 32'(wcount - wc0), 32'(exp_dat));
            chk("R7 commit count", 32'(ccount - cc0), 32'(exp_dat));
            if (exp_dat) begin
                chk("R4 written address", 32'(wlog_addr[wc0]), 32'(WTAB[t].addr));
                chk("R4 written data", 32'(wlog_data[wc0]), 32'(WTAB[t].data));
            end
            wr_protect = 1'b0;
        end
        chk("R5 protected location unchanged", 32'(mem[8'h11]), 32'(8'h11 ^ 8'h96));

        // R4 page write wrapping inside the page
        wc0 = wcount; cc0 = ccount;
        bus_start();
        send_byte(8'hAA, a);
        send_byte(8'h00, a);
        send_byte(8'h3E, a);
        send_byte(8'h11, a);
        send_byte(8'h22, a);
        send_byte(8'h33, a);
        chk("R4 third page byte acknowledge", 32'(a), 1);
        bus_stop();
        wq(4);
        chk("R4 page byte count", 32'(wcount - wc0), 3);
        chk("R4 page addr 0", 32'(wlog_addr[wc0]), 32'h003E);
        chk("R4 page addr 1", 32'(wlog_addr[wc0+1]), 32'h003F);
        chk("R4 page wraps", 32'(wlog_addr[wc0+2]), 32'h0000);
        chk("R7 single commit for page", 32'(ccount - cc0), 1);

        // R8 R9 random read via repeated start
        cc0 = ccount;
        bus_start();
        send_byte(8'hAA, a);
        send_byte(8'h00, a);
        send_byte(8'h10, a);
        bus_start();
        send_byte(8'hAB, a);
        chk("R9 read select after repeated start", 32'(a), 1);
        recv_byte(1'b1, rb);
        chk("R8 first read byte", 32'(rb), 32'h5A);
        recv_byte(1'b0, rb);
        chk("R8 incremented read byte", 32'(rb), 32'(8'h11 ^ 8'h96));
        bus_stop();
        wq(4);
        chk("R8 line released after no-ack", 32'(sda_oe), 0);
        chk("R9 no commit on read", 32'(ccount - cc0), 0);

        // R8 full 16-bit address wrap in reads
        bus_start();
        send_byte(8'hAA, a);
        send_byte(8'hFF, a);
        send_byte(8'hFF, a);
        bus_start();
        send_byte(8'hAB, a);
        recv_byte(1'b1, rb);
        chk("R8 byte at top address", 32'(rb), 32'(8'hFF ^ 8'h96));
        recv_byte(1'b0, rb);
        chk("R8 read wraps to zero", 32'(rb), 32'h33);
        bus_stop();

        // R7 stop right after address bytes
        wc0 = wcount; cc0 = ccount;
        bus_start();
        send_byte(8'hAA, a);
        send_byte(8'h00, a);
        send_byte(8'h50, a);
        bus_stop();
        wq(4);
        chk("R7 no commit after address only", 32'(ccount - cc0), 0);

        // R7 stop in the middle of the second data byte
        bus_start();
        send_byte(8'hAA, a);
        send_byte(8'h00, a);
        send_byte(8'h50, a);
        send_byte(8'hE1, a);
        for (int i = 0; i < 4; i++) send_bit(1'b1);
        bus_stop();
        wq(4);
        chk("R7 accepted byte strobed", 32'(wcount - wc0), 1);
        chk("R7 no commit on mid-byte stop", 32'(ccount - cc0), 0);

        // R9 repeated start after an accepted data byte discards it
        cc0 = ccount;
        bus_start();
        send_byte(8'hAA, a);
        send_byte(8'h00, a);
        send_byte(8'h60, a);
        send_byte(8'h3C, a);
        bus_start();
        send_byte(8'hAB, a);
        recv_byte(1'b0, rb);
        bus_stop();
        wq(4);
        chk("R9 no commit after repeated start", 32'(ccount - cc0), 0);

        // R3 busy engine: select not acknowledged
        busy = 1'b1;
        bus_start();
        send_byte(8'hAA, a);
        chk("R3 select refused while busy", 32'(a), 0);
        bus_stop();
        busy = 1'b0;
        bus_start();
        send_byte(8'hAA, a);
        chk("R3 select accepted after busy", 32'(a), 1);
        bus_stop();

        // R2 mismatch ignores following bytes
        bus_start();
        send_byte(8'hAC, a);
        chk("R2 mismatched chip code refused", 32'(a), 0);
        send_byte(8'hAA, a);
        chk("R2 later byte ignored", 32'(a), 0);
        bus_stop();
        wq(4);

        chk("R6 drive changes only with clock low", 32'(oe_viol), 0);
        chk("R10 strobe width", 32'(we_run), 0);

        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

endmodule